// File: doc/BRIEF.md
# Cartridge Bank-Switch and Write-Port RAM Controller

This block is the control logic of a game cartridge for a 6502-family console. The cartridge slot has no read/write line, so every decision comes from a 13-bit address bus. From that bus the block produces a ROM chip enable, a RAM chip enable, the ROM bank address bits and a RAM write strobe. A build parameter selects one of three ROM sizes: 8K with 2 banks, 16K with 4 banks, or 32K with 8 banks of 4K. Every size also has a 128-byte auxiliary RAM.

The RAM uses the lowest 256 bytes of cartridge space. Offsets $000-$07F are the write port and offsets $080-$0FF are the read port of the same 128 bytes. Address bit 7 therefore tells a store from a load. The write strobe is timed only from how long the address has been stable. A fast sampling clock counts cycles since the last address change, and counter thresholds take the place of the analog delay networks a discrete design would use.

A ROM bank is chosen by accessing a hotspot offset near the top of the 4K window. A read and a write both count as an access. The hotspot is acted on only once the address has held for a settle delay, so short bus glitches do not change the bank. Read-modify-write instructions on the RAM are not supported.

Top module: `cart_ctl`

## Requirements
- R1: While reset is held and after it is released, `rom_bank` holds the highest bank number (NBANK-1: 7 for MODE=2, 3 for MODE=1, 1 for MODE=0) and `ram_we` is 0.
- R2: `ram_en` is 1 in the same cycle exactly when `addr[12]`=1 and `addr[11:8]`=0.
- R3: `rom_en` is 1 in the same cycle exactly when `addr[12]`=1 and `ram_en` is 0, so the two enables are never 1 together.
- R4: `ram_w` never rises for an address in the read port (`addr[12]`=1, `addr[11:8]`=0, `addr[7]`=1). For example, a load from $1090 produces no strobe.
- R5: For a write-port address held for A clock edges, `ram_we` is 1 exactly when WE_ON <= A < WE_OFF. An absolute store such as $1060 therefore gives exactly one rising edge.
- R6: An indexed store presents its final write-port address twice with a brief different address between them. It yields two rising edges, and the RAM ends up holding the final data at the final location while other locations stay unchanged.
- R7: In MODE=2 (32K), holding offset $FF4+n (n = 0 to 7, with `addr[12]`=1) for HS_DLY+1 edges sets `rom_bank` to n. The update appears after exactly HS_DLY+1 edges of a stable address.
- R8: In MODE=1 the hotspots are offsets $FF6-$FF9 (bank = offset-$FF6). In MODE=0 they are $FF8-$FF9 (bank = offset-$FF8). Other offsets, such as $FF4 or $FFA, leave the bank unchanged.
- R9: A hotspot address held for fewer than HS_DLY edges does not change the bank.
- R10: With `addr[12]`=0, both enables are 0, `ram_we` stays 0 and no hotspot acts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the delay counters |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 13 | Cartridge address bus; bit 12 is the cartridge select |
| rom_en | output | 1 | ROM chip enable, active high |
| ram_en | output | 1 | Auxiliary RAM chip enable, active high |
| ram_we | output | 1 | RAM write strobe, active high |
| rom_bank | output | BANK_W | ROM bank address bits (clog2 of the bank count) |

## Verification
The enables are combinational and are due in the same cycle the address is driven. The bench compares them 2 ns after every rising edge. The write strobe and the bank register depend on the number of edges since the address last changed. The bench's reference model keeps its own count of that age: an address new at an edge has age 1. The model expects the strobe over ages WE_ON to WE_OFF-1 and the bank update at age HS_DLY+1. Three instances, one for each ROM size, share the address bus and are checked every cycle. Counts of strobe edges and the contents of the modelled RAM are checked after each bus operation.

// File: rtl/cart_pkg.sv
package cart_pkg;
  // bank count for a ROM size selector: 0 -> 8K, 1 -> 16K, 2 -> 32K
  function automatic int bank_count(input int mode);
    return 2 << mode;
  endfunction

  // first hotspot offset within the 4K window
  function automatic int hot_lo(input int mode);
    return 'hFF8 - 2 * mode;
  endfunction
endpackage

// File: rtl/cart_rst_sync.sv
module cart_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cart_addr_settle.sv
module cart_addr_settle #(
  parameter int AW   = 13,
  parameter int CW   = 8,
  parameter int CMAX = 187
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_q_o,
  output logic [CW-1:0] cnt_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          moved, cnt_en;

  always_comb begin
    moved  = (addr_i != addr_q);
    cnt_en = moved || (cnt_q != CW'(CMAX));
    addr_d = addr_i;
    cnt_d  = moved ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign addr_q_o = addr_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/cart_bank_ctl.sv
module cart_bank_ctl #(
  parameter int MODE   = 2,
  parameter int HS_DLY = 75,
  parameter int CW     = 8,
  localparam int NB     = cart_pkg::bank_count(MODE),
  localparam int BANK_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [12:0]       addr_q_i,
  input  logic [CW-1:0]     cnt_i,
  output logic [BANK_W-1:0] bank_o
);
  localparam int HLO = cart_pkg::hot_lo(MODE);
  localparam int HHI = HLO + NB - 1;

  logic              hit, fire;
  logic [BANK_W-1:0] bank_q, bank_d;

  always_comb begin
    hit    = addr_q_i[12] && (addr_q_i[11:0] >= 12'(HLO)) && (addr_q_i[11:0] <= 12'(HHI));
    fire   = hit && (cnt_i == CW'(HS_DLY - 1));
    bank_d = BANK_W'(addr_q_i[11:0] - 12'(HLO));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank_q <= BANK_W'(NB - 1);
    else if (fire) bank_q <= bank_d;
  end

  assign bank_o = bank_q;

  // R7 R9: the bank moves only after a settled cartridge-space address
  assert_bank_settled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q != $past(bank_q)) |-> ($past(addr_q_i[12]) && ($past(cnt_i) == CW'(HS_DLY - 1))));
endmodule

// File: rtl/cart_we_gen.sv
module cart_we_gen #(
  parameter int WE_ON  = 137,
  parameter int WE_OFF = 187,
  parameter int CW     = 8
) (
  input  logic [5:0]    win_i,
  input  logic [CW-1:0] cnt_i,
  output logic          we_o
);
  logic in_wport, in_time;

  always_comb begin
    in_wport = win_i[5] && (win_i[4:1] == 4'd0) && !win_i[0];
    in_time  = (cnt_i >= CW'(WE_ON - 1)) && (cnt_i < CW'(WE_OFF - 1));
    we_o     = in_wport && in_time;
  end
endmodule

// File: rtl/cart_ctl.sv
module cart_ctl #(
  parameter int MODE   = 2,
  parameter int HS_DLY = 75,
  parameter int WE_ON  = 137,
  parameter int WE_OFF = 187,
  localparam int NBANK  = cart_pkg::bank_count(MODE),
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [12:0]       addr,
  output logic              rom_en,
  output logic              ram_en,
  output logic              ram_we,
  output logic [BANK_W-1:0] rom_bank
);
  localparam int CW = $clog2(WE_OFF + 1);

  logic          srst_n;
  logic [12:0]   addr_q;
  logic [CW-1:0] cnt;

  cart_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  cart_addr_settle #(.AW(13), .CW(CW), .CMAX(WE_OFF)) u_settle (
    .clk(clk), .rst_n(srst_n), .addr_i(addr), .addr_q_o(addr_q), .cnt_o(cnt));

  cart_bank_ctl #(.MODE(MODE), .HS_DLY(HS_DLY), .CW(CW)) u_bank (
    .clk(clk), .rst_n(srst_n), .addr_q_i(addr_q), .cnt_i(cnt), .bank_o(rom_bank));

  cart_we_gen #(.WE_ON(WE_ON), .WE_OFF(WE_OFF), .CW(CW)) u_we (
    .win_i(addr_q[12:7]), .cnt_i(cnt), .we_o(ram_we));

  always_comb begin
    ram_en = addr[12] && (addr[11:8] == 4'd0);
    rom_en = addr[12] && !ram_en;
  end

  // R3: the chip enables exclude each other
  assert_enables_exclusive_R3: assert property (@(posedge clk) disable iff (!srst_n)
    !(ram_en && rom_en));

  // R4: a strobe on a stable bus lands in the write port only
  assert_strobe_write_port_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (ram_we && $stable(addr)) |-> (ram_en && !addr[7]));

  // R5: the strobe starts only on an address that has settled
  assert_strobe_settled_R5: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(ram_we) |-> (addr == $past(addr)));
endmodule

// File: tb/tb_cart_ctl.sv
module tb_cart_ctl;
  localparam int HS_DLY = 75;
  localparam int WE_ON  = 137;
  localparam int WE_OFF = 187;
  localparam int BUS    = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;

  logic       rom_en2, ram_en2, ram_we2;
  logic [2:0] bank2;
  logic       rom_en1, ram_en1, ram_we1;
  logic [1:0] bank1;
  logic       rom_en0, ram_en0, ram_we0;
  logic [0:0] bank0;

  always #4 clk = ~clk;

  cart_ctl #(.MODE(2), .HS_DLY(HS_DLY), .WE_ON(WE_ON), .WE_OFF(WE_OFF)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rom_en(rom_en2), .ram_en(ram_en2),
    .ram_we(ram_we2), .rom_bank(bank2));
  cart_ctl #(.MODE(1), .HS_DLY(HS_DLY), .WE_ON(WE_ON), .WE_OFF(WE_OFF)) dut_m1 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rom_en(rom_en1), .ram_en(ram_en1),
    .ram_we(ram_we1), .rom_bank(bank1));
  cart_ctl #(.MODE(0), .HS_DLY(HS_DLY), .WE_ON(WE_ON), .WE_OFF(WE_OFF)) dut_m0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rom_en(rom_en0), .ram_en(ram_en0),
    .ram_we(ram_we0), .rom_bank(bank0));

  int compared = 0;
  int mismatched = 0;
  bit checking = 0;
  bit done = 0;
  int age = 0;
  logic [12:0] last_addr = '0;
  int m_bank [3];
  logic [7:0] mem [128];
  int edges = 0;
  logic prev_we = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // hotspot table per ROM size, written from the requirements
  function automatic int hot_sel(input int mode, input logic [12:0] a);
    int lo, hi;
    case (mode)
      0: begin lo = 'hFF8; hi = 'hFF9; end
      1: begin lo = 'hFF6; hi = 'hFF9; end
      default: begin lo = 'hFF4; hi = 'hFFB; end
    endcase
    if (a[12] && int'(a[11:0]) >= lo && int'(a[11:0]) <= hi) return int'(a[11:0]) - lo;
    return -1;
  endfunction

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // per-clock reference model and comparison
  always @(posedge clk) begin
    if (addr != last_addr) begin
      age = 1;
      last_addr = addr;
    end else if (age < 100000) age++;
    for (int m = 0; m < 3; m++) begin
      if (checking && age == HS_DLY + 1 && hot_sel(m, addr) >= 0) m_bank[m] = hot_sel(m, addr);
    end
    #2;
    if (ram_we2) mem[addr[6:0]] = wdata;
    if (ram_we2 && !prev_we) edges++;
    prev_we = ram_we2;
    if (checking) begin
      automatic bit exp_ram = addr[12] && addr[11:8] == 4'd0;
      automatic bit exp_rom = addr[12] && !exp_ram;
      automatic bit exp_we  = exp_ram && !addr[7] && age >= WE_ON && age < WE_OFF;
      chk("R2 ram_en", ram_en2, exp_ram);
      chk("R2 ram_en m1", ram_en1, exp_ram);
      chk("R2 ram_en m0", ram_en0, exp_ram);
      chk("R3 rom_en", rom_en2, exp_rom);
      chk("R3 rom_en m1", rom_en1, exp_rom);
      chk("R3 rom_en m0", rom_en0, exp_rom);
      chk("R5 ram_we", ram_we2, exp_we);
      chk("R5 ram_we m1", ram_we1, exp_we);
      chk("R5 ram_we m0", ram_we0, exp_we);
      chk("R7 rom_bank", bank2, m_bank[2]);
      chk("R8 rom_bank m1", bank1, m_bank[1]);
      chk("R8 rom_bank m0", bank0, m_bank[0]);
    end
  end

  task automatic bus(input logic [12:0] a, input logic [7:0] d, input int n);
    @(negedge clk);
    addr = a;
    wdata = d;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual expired expected finished");
    report();
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    m_bank[0] = 1;
    m_bank[1] = 3;
    m_bank[2] = 7;
    repeat (4) @(negedge clk);
    chk("R1 reset bank", bank2, 7);
    chk("R1 reset bank m1", bank1, 3);
    chk("R1 reset bank m0", bank0, 1);
    chk("R1 reset we", ram_we2, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 bank after release", bank2, 7);
    checking = 1;

    // absolute store to the write port
    edges = 0;
    bus(13'h1060, 8'hA5, BUS);
    chk("R5 absolute store edges", edges, 1);
    chk("R5 stored data", mem[8'h60], 8'hA5);

    // indexed store: final address, bus transition, final address again
    edges = 0;
    bus(13'h1040, 8'hEE, BUS);
    bus(13'h1140, 8'hEE, 3);
    bus(13'h1040, 8'h3C, BUS);
    chk("R6 indexed store edges", edges, 2);
    chk("R6 final data", mem[8'h40], 8'h3C);
    chk("R6 neighbour untouched", mem[8'h20], 8'h00);

    // load from the read port
    edges = 0;
    bus(13'h1090, 8'h55, BUS);
    chk("R4 load edges", edges, 0);
    chk("R4 memory unchanged", mem[8'h10], 8'h00);
    bus(13'h10E0, 8'h55, BUS);
    chk("R4 read-port alias edges", edges, 0);
    chk("R4 readback", mem[8'h60], 8'hA5);

    // cartridge deselected
    edges = 0;
    bus(13'h0060, 8'h77, BUS);
    chk("R10 no strobe when deselected", edges, 0);
    chk("R10 memory unchanged", mem[8'h60], 8'hA5);
    bus(13'h0FF5, 8'h00, BUS);
    chk("R10 hotspot ignored", bank2, 7);

    // hotspot sweep across all sizes
    for (int n = 0; n < 8; n++) begin
      bus(13'h1FF4 + 13'(n), 8'h00, BUS);
      chk("R7 bank select", bank2, n);
      chk("R8 bank m1", bank1, m_bank[1]);
      chk("R8 bank m0", bank0, m_bank[0]);
    end
    bus(13'h1FF8, 8'h00, BUS);
    chk("R8 m0 FF8", bank0, 0);
    chk("R8 m1 FF8", bank1, 2);
    bus(13'h1FFB, 8'h00, BUS);
    chk("R8 m0 FFB ignored", bank0, 0);
    chk("R8 m1 FFB ignored", bank1, 2);
    chk("R7 FFB", bank2, 7);

    // glitch shorter than the settle delay
    bus(13'h1FF5, 8'h00, 10);
    bus(13'h1800, 8'h00, BUS);
    chk("R9 glitch ignored", bank2, 7);
    bus(13'h1FF6, 8'h00, HS_DLY - 1);
    bus(13'h1800, 8'h00, BUS);
    chk("R9 short hold ignored", bank2, 7);
    chk("R9 short hold ignored m1", bank1, 2);

    report();
  end
endmodule